// File: doc/BRIEF.md
# Dual-Channel Threshold and Slope Alarm

This block watches two alarm channels. Each channel is set up on its own. A channel picks one data word from a small set of candidates: the angular-rate word, the temperature word or the status word. On every sample strobe it tests that word in one of two ways. In level mode it compares the value itself with a signed limit. In slope mode it compares the change in the value over a programmed number of past samples with that limit. A per-channel direction bit chooses whether the channel fires above the limit or below it.

A channel that fires sets a sticky flag in a 16-bit status output. A read strobe from the host clears the flags. A condition that is still true sets its flag again at the next sample. A shared hardware indicator shows whether either channel's condition is currently active. The indicator can be switched off, steered to either of two output pins, and given either active level. Producing the data words is outside this block.

Top module: `alm_dual_monitor`

## Requirements
- R1: Source codes per channel: 0 = off, 1 = rate word, 2 = temperature word, 3 = status word. Codes 0 and 4 to 15 never raise a condition or a flag.
- R2: When `use_filt` is 1, the rate and temperature sources come from the filtered inputs; when it is 0 they come from the raw inputs. The status word source is the same in both cases.
- R3: In level mode (`ch_slope` bit = 0), the sampled value and the threshold are both treated as signed two's complement and compared on each sample strobe.
- R4: A direction bit of 1 fires when the tested quantity is strictly greater than the threshold. A direction bit of 0 fires when it is strictly less. Equality never fires.
- R5: In slope mode (`ch_slope` bit = 1), the tested quantity is the current sample minus the sample taken N strobes earlier. N comes from the 8-bit span: 0 and 1 both mean N = 1, and any N above the history depth is treated as the depth.
- R6: In slope mode a channel cannot fire until it has stored at least N samples since reset.
- R7: Flags are sticky. Channel 0 sits at status bit 8 and channel 1 at bit 9; every other status bit is 0. A flag becomes visible in the cycle after the strobe that raised it.
- R8: A `stat_rd` pulse clears both flags in the next cycle. A channel that fires on a strobe in the same cycle as the read keeps its flag set.
- R9: A channel's active condition changes only on a sample strobe and holds its value between strobes.
- R10: Indicator control: `ind_ctl[2]` enables the indicator, `ind_ctl[1]` chooses the pin (0 = `ind_pin[0]`, 1 = `ind_pin[1]`), and `ind_ctl[0]` sets the level (1 = high when active). The selected pin carries the OR of the two active conditions at that level. The other pin is 0, and both pins are 0 when the indicator is disabled.
- R11: After reset, both flags and both conditions are 0 and both histories are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | One-cycle strobe marking a new sample |
| stat_rd | input | 1 | Host read of the status word; clears the flags |
| rate_raw | input | DATA_W | Unfiltered rate word |
| rate_filt | input | DATA_W | Filtered rate word |
| temp_raw | input | DATA_W | Unfiltered temperature word |
| temp_filt | input | DATA_W | Filtered temperature word |
| stat_word | input | DATA_W | Status word offered as a source |
| use_filt | input | 1 | Chooses filtered (1) or raw (0) rate and temperature |
| ch_src | input | 2x4 | Source code for each channel |
| ch_slope | input | 2 | Mode for each channel: 0 level, 1 slope |
| ch_above | input | 2 | Direction for each channel: 1 greater-than, 0 less-than |
| ch_thr | input | 2xDATA_W | Signed threshold for each channel |
| ch_span | input | 2x8 | Slope span in samples for each channel |
| ind_ctl | input | 3 | Indicator enable, pin choice and level |
| alarm_status | output | 16 | Sticky flags at bits 9 and 8 |
| ind_pin | output | 2 | Hardware indicator pins |

## Verification
The bench sets the history depth to 8 and keeps the data width at 16. With a depth of 8, the buffer wraps within a few dozen strobes. A span of 20 then shows the clamp to the depth, while spans 0, 1 and 3 exercise short look-backs and the start-up wait before a full window exists. The 16-bit signed width lets the bench use negative thresholds, equality at the limit and a status word with its top bit set, all in small numbers of strobes.

// File: rtl/alm_pkg.sv
// Package: shared codes and field positions for the dual alarm monitor.
// Assumes: source codes are 4 bits wide; status flags live in a 16-bit word.
package alm_pkg;
    typedef enum logic [3:0] {
        SRC_OFF  = 4'd0,
        SRC_RATE = 4'd1,
        SRC_TEMP = 4'd2,
        SRC_STAT = 4'd3
    } alm_src_e;

    localparam int NUM_CH      = 2;
    localparam int STAT_W      = 16;
    localparam int FLAG_LSB    = 8;
    localparam int SPAN_W      = 8;
    localparam int IND_EN_BIT  = 2;
    localparam int IND_PIN_BIT = 1;
    localparam int IND_LVL_BIT = 0;
endpackage

// File: rtl/alm_src_mux.sv
// Module: picks the data word a channel monitors.
// Assumes: codes outside the defined set are treated as "off" and yield zero.
module alm_src_mux
    import alm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        sel,
    input  logic              use_filt,
    input  logic [DATA_W-1:0] rate_raw,
    input  logic [DATA_W-1:0] rate_filt,
    input  logic [DATA_W-1:0] temp_raw,
    input  logic [DATA_W-1:0] temp_filt,
    input  logic [DATA_W-1:0] stat_word,
    output logic [DATA_W-1:0] val,
    output logic              src_ok
);
    // Decode the source code into the selected word and a valid flag.
    always_comb begin
        val    = '0;
        src_ok = 1'b0;
        case (sel)
            SRC_RATE: begin val = use_filt ? rate_filt : rate_raw; src_ok = 1'b1; end
            SRC_TEMP: begin val = use_filt ? temp_filt : temp_raw; src_ok = 1'b1; end
            SRC_STAT: begin val = stat_word;                       src_ok = 1'b1; end
            default:  begin val = '0;                              src_ok = 1'b0; end
        endcase
    end
endmodule

// File: rtl/alm_slope_hist.sv
// Module: circular history of past samples, giving current minus N-back.
// Assumes: 2 <= DEPTH <= 255; the span is static while a channel is in use.
module alm_slope_hist
    import alm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 255
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [DATA_W-1:0]        din,
    input  logic [SPAN_W-1:0]        span,
    output logic signed [DATA_W:0]   delta,
    output logic                     ready
);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam logic [8:0] DEPTH9 = 9'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [FILL_W-1:0] fill;
    logic [8:0]        n_eff;
    logic [8:0]        wr_ext;
    logic [8:0]        rd_w;
    logic [PTR_W-1:0]  rd_idx;
    logic [DATA_W-1:0] old_val;

    // Effective look-back: 0/1 mean one, clamp to buffer depth.
    always_comb begin
        if (span <= 8'd1)
            n_eff = 9'd1;
        else if ({1'b0, span} > DEPTH9)
            n_eff = DEPTH9;
        else
            n_eff = {1'b0, span};
    end

    // Read index N entries behind the write pointer, wrapping modulo DEPTH.
    always_comb begin
        wr_ext  = 9'(wr_ptr);
        rd_w    = (wr_ext >= n_eff) ? (wr_ext - n_eff) : (wr_ext + DEPTH9 - n_eff);
        rd_idx  = rd_w[PTR_W-1:0];
        old_val = mem[rd_idx];
        delta   = $signed({din[DATA_W-1], din}) - $signed({old_val[DATA_W-1], old_val});
        ready   = (9'(fill) >= n_eff);
    end

    // Store each sample and advance the write pointer.
    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= din;
    end

    // Track pointer and saturating fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else if (push) begin
            wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (fill != FILL_W'(DEPTH))
                fill <= fill + 1'b1;
        end
    end

    a_r6_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(DEPTH));
    a_r6_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fill != FILL_W'(DEPTH)) |=> fill == $past(fill) + 1'b1);
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(wr_ptr));
endmodule

// File: rtl/alm_channel.sv
// Module: one alarm channel - source pick, level or slope test, sticky flag.
// Assumes: configuration is static while the channel is in use.
module alm_channel
    import alm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              rd_clr,
    input  logic [3:0]        src_sel,
    input  logic              use_filt,
    input  logic [DATA_W-1:0] rate_raw,
    input  logic [DATA_W-1:0] rate_filt,
    input  logic [DATA_W-1:0] temp_raw,
    input  logic [DATA_W-1:0] temp_filt,
    input  logic [DATA_W-1:0] stat_word,
    input  logic              slope_mode,
    input  logic              above,
    input  logic [DATA_W-1:0] thr,
    input  logic [SPAN_W-1:0] span,
    output logic              cond,
    output logic              flag
);
    logic [DATA_W-1:0]      val;
    logic                   src_ok;
    logic signed [DATA_W:0] delta;
    logic                   hist_ready;
    logic signed [DATA_W:0] operand;
    logic signed [DATA_W:0] thr_x;
    logic                   hit;

    alm_src_mux #(.DATA_W(DATA_W)) u_mux (
        .sel       (src_sel),
        .use_filt  (use_filt),
        .rate_raw  (rate_raw),
        .rate_filt (rate_filt),
        .temp_raw  (temp_raw),
        .temp_filt (temp_filt),
        .stat_word (stat_word),
        .val       (val),
        .src_ok    (src_ok)
    );

    alm_slope_hist #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (sample),
        .din   (val),
        .span  (span),
        .delta (delta),
        .ready (hist_ready)
    );

    // Signed comparison of level or slope against the threshold.
    always_comb begin
        thr_x   = $signed({thr[DATA_W-1], thr});
        operand = slope_mode ? delta : $signed({val[DATA_W-1], val});
        hit     = src_ok && (!slope_mode || hist_ready) &&
                  (above ? (operand > thr_x) : (operand < thr_x));
    end

    // Condition follows the test on strobes; flag is sticky, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (sample)
                cond <= hit;
            if (sample && hit)
                flag <= 1'b1;
            else if (rd_clr)
                flag <= 1'b0;
        end
    end

    a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !src_ok) |=> !cond);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !rd_clr) |=> flag);
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !sample) |=> !flag);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> $stable(cond));
    a_r6_wait_window: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && slope_mode && !hist_ready) |=> !cond);
endmodule

// File: rtl/alm_dual_monitor.sv
// Module: top of the dual alarm monitor - two channels, status word, indicator.
// Assumes: sample_stb is a single-cycle pulse; stat_rd pulses once per host read.
module alm_dual_monitor
    import alm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 255
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sample_stb,
    input  logic                            stat_rd,
    input  logic [DATA_W-1:0]               rate_raw,
    input  logic [DATA_W-1:0]               rate_filt,
    input  logic [DATA_W-1:0]               temp_raw,
    input  logic [DATA_W-1:0]               temp_filt,
    input  logic [DATA_W-1:0]               stat_word,
    input  logic                            use_filt,
    input  logic [NUM_CH-1:0][3:0]          ch_src,
    input  logic [NUM_CH-1:0]               ch_slope,
    input  logic [NUM_CH-1:0]               ch_above,
    input  logic [NUM_CH-1:0][DATA_W-1:0]   ch_thr,
    input  logic [NUM_CH-1:0][SPAN_W-1:0]   ch_span,
    input  logic [2:0]                      ind_ctl,
    output logic [STAT_W-1:0]               alarm_status,
    output logic [1:0]                      ind_pin
);
    logic [NUM_CH-1:0] cond;
    logic [NUM_CH-1:0] flag;
    logic              any_active;
    logic              level;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        alm_channel #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample     (sample_stb),
            .rd_clr     (stat_rd),
            .src_sel    (ch_src[c]),
            .use_filt   (use_filt),
            .rate_raw   (rate_raw),
            .rate_filt  (rate_filt),
            .temp_raw   (temp_raw),
            .temp_filt  (temp_filt),
            .stat_word  (stat_word),
            .slope_mode (ch_slope[c]),
            .above      (ch_above[c]),
            .thr        (ch_thr[c]),
            .span       (ch_span[c]),
            .cond       (cond[c]),
            .flag       (flag[c])
        );
    end

    // Place the sticky flags into the status word.
    always_comb begin
        alarm_status = '0;
        alarm_status[FLAG_LSB +: NUM_CH] = flag;
    end

    // Route the OR of active conditions to the chosen pin at the chosen level.
    always_comb begin
        any_active = |cond;
        level      = ind_ctl[IND_LVL_BIT] ? any_active : !any_active;
        ind_pin    = 2'b00;
        if (ind_ctl[IND_EN_BIT])
            ind_pin[ind_ctl[IND_PIN_BIT]] = level;
    end

    a_r10_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ind_pin));
    a_r10_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ind_ctl[IND_EN_BIT] |-> ind_pin == 2'b00);
    a_r7_other_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(alarm_status) <= NUM_CH);
endmodule

// File: tb/alm_dual_monitor_tb.sv
module alm_dual_monitor_tb;
    localparam int DW = 16;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_stb = 1'b0, stat_rd = 1'b0, use_filt = 1'b0;
    logic [DW-1:0] rate_raw = '0, rate_filt = '0, temp_raw = '0, temp_filt = '0, stat_word = '0;
    logic [1:0][3:0] ch_src = '0;
    logic [1:0] ch_slope = '0, ch_above = '0;
    logic [1:0][DW-1:0] ch_thr = '0;
    logic [1:0][7:0] ch_span = '0;
    logic [2:0] ind_ctl = '0;
    logic [15:0] alarm_status;
    logic [1:0] ind_pin;

    int checks = 0, errors = 0;
    string cur_req = "R11";
    bit done = 0;

    int q0[$], q1[$];
    bit m_cond0 = 0, m_cond1 = 0, m_flag0 = 0, m_flag1 = 0;

    always #2 clk = ~clk;

    alm_dual_monitor #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .stat_rd(stat_rd),
        .rate_raw(rate_raw), .rate_filt(rate_filt), .temp_raw(temp_raw),
        .temp_filt(temp_filt), .stat_word(stat_word), .use_filt(use_filt),
        .ch_src(ch_src), .ch_slope(ch_slope), .ch_above(ch_above),
        .ch_thr(ch_thr), .ch_span(ch_span), .ind_ctl(ind_ctl),
        .alarm_status(alarm_status), .ind_pin(ind_pin)
    );

    // Reference: the word a channel looks at, per the source-code table.
    function automatic int pick(input logic [3:0] s, output bit ok);
        ok = 1;
        case (s)
            4'd1: return use_filt ? int'($signed(rate_filt)) : int'($signed(rate_raw));
            4'd2: return use_filt ? int'($signed(temp_filt)) : int'($signed(temp_raw));
            4'd3: return int'($signed(stat_word));
            default: begin ok = 0; return 0; end
        endcase
    endfunction

    task automatic chan_step(input int c, ref int q[$], ref bit cnd, ref bit flg);
        bit ok;
        int v, n, x, thr;
        bit hit;
        v = pick(ch_src[c], ok);
        thr = int'($signed(ch_thr[c]));
        hit = 0;
        if (sample_stb) begin
            if (ok) begin
                if (ch_slope[c]) begin
                    n = (ch_span[c] <= 1) ? 1 : int'(ch_span[c]);
                    if (n > DEPTH) n = DEPTH;
                    if (q.size() >= n) begin
                        x = v - q[q.size() - n];
                        hit = ch_above[c] ? (x > thr) : (x < thr);
                    end
                end else begin
                    hit = ch_above[c] ? (v > thr) : (v < thr);
                end
            end
            q.push_back(v);
            if (q.size() > DEPTH) void'(q.pop_front());
            cnd = hit;
        end
        if (sample_stb && hit) flg = 1;
        else if (stat_rd) flg = 0;
    endtask

    function automatic logic [1:0] exp_pins();
        logic [1:0] p;
        bit lvl;
        p = 2'b00;
        lvl = ind_ctl[0] ? (m_cond0 | m_cond1) : !(m_cond0 | m_cond1);
        if (ind_ctl[2]) p[ind_ctl[1]] = lvl;
        return p;
    endfunction

    // Update the model at each edge, then compare 1 ns later.
    always @(posedge clk) begin
        if (!rst_n) begin
            q0.delete(); q1.delete();
            m_cond0 = 0; m_cond1 = 0; m_flag0 = 0; m_flag1 = 0;
        end else begin
            chan_step(0, q0, m_cond0, m_flag0);
            chan_step(1, q1, m_cond1, m_flag1);
        end
        #1;
        if (!done) begin
            checks++;
            if (alarm_status !== {6'd0, m_flag1, m_flag0, 8'd0}) begin
                errors++;
                $display("FAIL %s status actual=%h expected=%h", cur_req, alarm_status,
                         {6'd0, m_flag1, m_flag0, 8'd0});
            end
            checks++;
            if (ind_pin !== exp_pins()) begin
                errors++;
                $display("FAIL %s ind_pin actual=%b expected=%b", cur_req, ind_pin, exp_pins());
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic smp(input int rr, input int rf, input int tr, input int tf, input int sw);
        @(negedge clk);
        rate_raw = DW'(rr); rate_filt = DW'(rf);
        temp_raw = DW'(tr); temp_filt = DW'(tf); stat_word = DW'(sw);
        sample_stb = 1;
        @(negedge clk);
        sample_stb = 0;
    endtask

    task automatic rd();
        @(negedge clk); stat_rd = 1;
        @(negedge clk); stat_rd = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        idle(3);
        rst_n = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired in %s", cur_req);
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: reset state, indicator enabled active-low on pin 1
        cur_req = "R11";
        ind_ctl = 3'b110;
        idle(4);
        rst_n = 1;
        idle(3);

        // R3 and R4: level mode, strict comparisons, signed values
        cur_req = "R3";
        ind_ctl = 3'b101;
        ch_src[0] = 4'd1; ch_above[0] = 1; ch_thr[0] = 16'd100;
        ch_src[1] = 4'd2; ch_above[1] = 0; ch_thr[1] = -16'sd20;
        smp(50, 0, 10, 0, 0);
        cur_req = "R4";
        smp(100, 0, -20, 0, 0);
        smp(101, 0, -21, 0, 0);
        idle(2);
        smp(-300, 0, 500, 0, 0);
        rd();
        idle(1);

        // R2: filtered/raw selection
        cur_req = "R2";
        use_filt = 1;
        smp(0, 500, -100, 30, 0);
        rd();
        use_filt = 0;
        smp(0, 500, -100, 30, 0);
        rd();

        // R1: status source and disabled codes
        cur_req = "R1";
        ch_src[0] = 4'd3; ch_thr[0] = 16'd0; ch_above[0] = 1;
        ch_src[1] = 4'd0;
        smp(0, 0, -500, -500, 16'h8000);
        smp(0, 0, -500, -500, 5);
        ch_src[1] = 4'd9;
        smp(0, 0, -500, -500, 0);
        rd();
        ch_src[0] = 4'd15;
        smp(9999, 9999, 0, 0, 9999);
        rd();

        // R8: clear on read; hit in the read cycle keeps the flag
        cur_req = "R8";
        ch_src[0] = 4'd1; ch_thr[0] = 16'd10; ch_above[0] = 1;
        smp(20, 0, 0, 0, 0);
        rd();
        @(negedge clk);
        rate_raw = 16'd30; sample_stb = 1; stat_rd = 1;
        @(negedge clk);
        sample_stb = 0; stat_rd = 0;
        idle(2);
        rd();

        // R9: condition holds between strobes, flag stays
        cur_req = "R9";
        smp(40, 0, 0, 0, 0);
        idle(5);
        rate_raw = 16'd0;
        idle(3);
        smp(0, 0, 0, 0, 0);
        idle(3);

        // R6 and R5: slope mode after a fresh reset
        cur_req = "R6";
        do_reset();
        ch_src[0] = 4'd1; ch_slope[0] = 1; ch_above[0] = 1; ch_thr[0] = 16'd10; ch_span[0] = 8'd3;
        ch_src[1] = 4'd2; ch_slope[1] = 1; ch_above[1] = 0; ch_thr[1] = -16'sd5; ch_span[1] = 8'd0;
        smp(0, 0, 100, 0, 0);
        smp(50, 0, 90, 0, 0);
        smp(60, 0, 88, 0, 0);
        cur_req = "R5";
        smp(65, 0, 80, 0, 0);
        smp(66, 0, 81, 0, 0);
        rd();
        ch_span[1] = 8'd1;
        for (int i = 0; i < 20; i++) begin
            smp(i * 3 + ((i % 4 == 0) ? 20 : 0), 0, 100 - i * i, 0, 0);
            if (i % 5 == 4) rd();
        end
        ch_span[0] = 8'd20; ch_thr[0] = 16'd40;
        for (int i = 0; i < 20; i++) begin
            smp(i * 6, 0, i, 0, 0);
            if (i % 3 == 2) rd();
        end
        ch_span[0] = 8'd0; ch_above[0] = 0; ch_thr[0] = -16'sd1;
        smp(100, 0, 0, 0, 0);
        smp(-100, 0, 0, 0, 0);
        smp(-100, 0, 0, 0, 0);
        rd();

        // R10: indicator routing and level
        cur_req = "R10";
        ch_slope = '0; ch_src[0] = 4'd1; ch_above[0] = 1; ch_thr[0] = 16'd0;
        ch_src[1] = 4'd0;
        for (int k = 0; k < 8; k++) begin
            ind_ctl = 3'(k);
            smp(5, 0, 0, 0, 0);
            idle(1);
            smp(-5, 0, 0, 0, 0);
            idle(1);
        end
        ch_src[1] = 4'd2; ch_above[1] = 1; ch_thr[1] = 16'd0;
        ind_ctl = 3'b111;
        smp(-5, 0, 7, 0, 0);
        idle(2);
        ind_ctl = 3'b100;
        idle(2);

        // R7: flags visible one cycle after the strobe, bits 8 and 9 only
        cur_req = "R7";
        rd();
        smp(5, 0, 5, 0, 0);
        idle(3);
        rd();
        idle(2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule